// File: doc/BRIEF.md
# Shared Two-Port Word Memory with Collision Busy Flags

This block is a clocked memory that two independent agents, a left port and a right port, can read and write at the same time. Each port has its own address, write data and read data. Each port also has a pair of enable inputs, a write strobe, an output enable, and two half-word lane selects.

When both enabled ports present the same word address in one cycle, an arbiter lets the left port through and raises a busy flag toward the right port. Any write from the flagged port in that cycle is dropped.

A master/slave strap sets where the busy information comes from. A master device makes busy itself and drives it out on its busy outputs. A slave device holds its busy outputs low and takes busy from its busy inputs, which are wired to a master's busy outputs. This lets several devices sit side by side to form a wider word, and all of them block the same port on a collision.

Read data is registered. It appears one cycle after the request, and only when the port is enabled, its output enable is set, and it is not writing.

Top module: `dpram_busy`

## Requirements
- R1: A port is enabled only in a cycle where its low-active enable is 0 and its high-active enable is 1. A write attempted with either enable inactive leaves the memory unchanged.
- R2: On the clock edge, a port's read data register loads the addressed word if the port is enabled, its output enable is 1 and its write strobe is 1 (read). In every other case the register loads zero. The value is therefore visible one cycle after the request, and reset clears it.
- R3: A write (enabled, write strobe 0) updates only the selected lanes. The lower lane select covers bits [DATA_W/2-1:0], which is bits 0..8 when DATA_W is 18. The upper lane select covers the remaining high bits, which is bits 9..17 when DATA_W is 18.
- R4: On a read, a lane whose select is 0 returns zeros in that lane's bit positions.
- R5: In master mode (strap 1), when both ports are enabled with equal addresses, the right busy output is 1 and the left busy output is 0 in that same cycle.
- R6: A port whose effective busy is 1 has its write suppressed for that cycle. Effective busy is the arbiter result in master mode and the busy input in slave mode.
- R7: In slave mode (strap 0), both busy outputs are 0, and a port's busy input being 1 blocks that port's write.
- R8: When one port writes a word that the other port reads in the same cycle, the reader receives the old contents. The new contents are returned to a read in the following cycle.
- R9: When the addresses differ, or when either port is disabled, neither busy output is raised and both ports proceed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 1 = master (busy generated here), 0 = slave (busy taken in) |
| l_ce_n | input | 1 | Left low-active enable |
| l_ce | input | 1 | Left high-active enable |
| l_we_n | input | 1 | Left write strobe, 0 = write, 1 = read |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper lane select |
| l_lb | input | 1 | Left lower lane select |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left registered read data |
| l_busy_in | input | 1 | Left busy from a master (slave mode) |
| l_busy_out | output | 1 | Left busy toward cascaded devices (master mode) |
| r_ce_n | input | 1 | Right low-active enable |
| r_ce | input | 1 | Right high-active enable |
| r_we_n | input | 1 | Right write strobe, 0 = write, 1 = read |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper lane select |
| r_lb | input | 1 | Right lower lane select |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right registered read data |
| r_busy_in | input | 1 | Right busy from a master (slave mode) |
| r_busy_out | output | 1 | Right busy toward cascaded devices (master mode) |

## Verification
The bench builds the block with DATA_W = 18 and ADDR_W = 4.

The odd lane width of 9 bits tests the lane split at bit 9 rather than at a byte boundary. A 16-word array makes random addresses on the two ports match in a useful fraction of cycles. Those matches exercise same-address collisions, suppressed writes and read-during-write ordering in both strap settings.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum int {
        SIDE_L = 0,
        SIDE_R = 1
    } side_e;

    typedef struct packed {
        logic en;
        logic rd;
        logic wr;
        logic ub;
        logic lb;
    } port_ctl_t;

endpackage

// File: rtl/dpram_port_ctl.sv
module dpram_port_ctl
    import dpram_pkg::*;
(
    input  logic      ce_n,
    input  logic      ce,
    input  logic      we_n,
    input  logic      oe,
    input  logic      ub,
    input  logic      lb,
    output port_ctl_t ctl
);
    always_comb begin
        ctl.en = ~ce_n & ce;
        ctl.wr = ctl.en & ~we_n;
        ctl.rd = ctl.en & we_n & oe;
        ctl.ub = ub;
        ctl.lb = lb;
    end
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  port_ctl_t         ctl_l,
    input  port_ctl_t         ctl_r,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic              busy_in_l,
    input  logic              busy_in_r,
    output logic              busy_out_l,
    output logic              busy_out_r,
    output logic              block_l,
    output logic              block_r
);
    logic clash;

    always_comb begin
        clash      = ctl_l.en && ctl_r.en && (addr_l == addr_r);
        // the left port wins a tie, so only the right port is ever flagged
        busy_out_l = 1'b0;
        busy_out_r = master_sel & clash;
        block_l    = master_sel ? 1'b0  : busy_in_l;
        block_r    = master_sel ? clash : busy_in_r;
    end

    // R5: same-address tie flags the right port only
    p_tie_right_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && ctl_l.en && ctl_r.en && addr_l == addr_r)
            |-> (busy_out_r && !busy_out_l));

    // R7: busy outputs are held low in slave mode
    p_slave_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |-> (!busy_out_l && !busy_out_r));

    // R9: distinct addresses never raise busy
    p_no_false_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_l != addr_r || !ctl_l.en || !ctl_r.en) |-> (!busy_out_l && !busy_out_r));
endmodule

// File: rtl/dpram_array.sv
module dpram_array
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_ctl_t         ctl    [2],
    input  logic [ADDR_W-1:0] addr   [2],
    input  logic [DATA_W-1:0] wdata  [2],
    input  logic              block  [2],
    output logic [DATA_W-1:0] rdata  [2]
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / 2;
    localparam int HI_W   = DATA_W - LANE_W;

    typedef struct {
        logic [DATA_W-1:0] rdata [2];
    } rd_state_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_state_t         st_d, st_q;
    logic              do_wr [2];

    always_comb begin
        for (int s = 0; s < 2; s++) begin
            do_wr[s] = ctl[s].wr & ~block[s];
            st_d.rdata[s] = '0;
            if (ctl[s].rd) begin
                if (ctl[s].lb) st_d.rdata[s][LANE_W-1:0]      = mem[addr[s]][LANE_W-1:0];
                if (ctl[s].ub) st_d.rdata[s][DATA_W-1:LANE_W] = mem[addr[s]][DATA_W-1:LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rdata[0] <= '0;
            st_q.rdata[1] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // right side first so that the left side has the last word on a shared address
    always_ff @(posedge clk) begin
        for (int s = 1; s >= 0; s--) begin
            if (do_wr[s]) begin
                if (ctl[s].lb) mem[addr[s]][LANE_W-1:0]      <= wdata[s][LANE_W-1:0];
                if (ctl[s].ub) mem[addr[s]][DATA_W-1:LANE_W] <= wdata[s][DATA_W-1:LANE_W];
            end
        end
    end

    always_comb begin
        rdata[0] = st_q.rdata[0];
        rdata[1] = st_q.rdata[1];
    end

    // R2: a port that is not reading returns zero next cycle
    p_idle_zero_l_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[SIDE_L].rd |=> (rdata[SIDE_L] == '0));
    p_idle_zero_r_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[SIDE_R].rd |=> (rdata[SIDE_R] == '0));

    // R6: a blocked right write leaves the word intact unless the left side writes it
    p_blocked_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl[SIDE_R].wr && block[SIDE_R] &&
         !(do_wr[SIDE_L] && addr[SIDE_L] == addr[SIDE_R]))
            |=> (mem[$past(addr[SIDE_R])] == $past(mem[addr[SIDE_R]])));

    // R8: full-word read during a write by the other side sees the old contents
    p_old_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr[SIDE_L] && ctl[SIDE_R].rd && ctl[SIDE_R].ub && ctl[SIDE_R].lb &&
         addr[SIDE_L] == addr[SIDE_R])
            |=> (rdata[SIDE_R] == $past(mem[addr[SIDE_R]])));

    localparam int unused_hi = HI_W;
endmodule

// File: rtl/dpram_busy.sv
module dpram_busy
    import dpram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              master_sel,
    input  logic              l_ce_n,
    input  logic              l_ce,
    input  logic              l_we_n,
    input  logic              l_oe,
    input  logic              l_ub,
    input  logic              l_lb,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              l_busy_in,
    output logic              l_busy_out,
    input  logic              r_ce_n,
    input  logic              r_ce,
    input  logic              r_we_n,
    input  logic              r_oe,
    input  logic              r_ub,
    input  logic              r_lb,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    input  logic              r_busy_in,
    output logic              r_busy_out
);
    logic              ce_n_v [2];
    logic              ce_v   [2];
    logic              we_n_v [2];
    logic              oe_v   [2];
    logic              ub_v   [2];
    logic              lb_v   [2];
    port_ctl_t         ctl    [2];
    logic [ADDR_W-1:0] addr   [2];
    logic [DATA_W-1:0] wdata  [2];
    logic [DATA_W-1:0] rdata  [2];
    logic              block  [2];

    always_comb begin
        ce_n_v[0] = l_ce_n;  ce_n_v[1] = r_ce_n;
        ce_v[0]   = l_ce;    ce_v[1]   = r_ce;
        we_n_v[0] = l_we_n;  we_n_v[1] = r_we_n;
        oe_v[0]   = l_oe;    oe_v[1]   = r_oe;
        ub_v[0]   = l_ub;    ub_v[1]   = r_ub;
        lb_v[0]   = l_lb;    lb_v[1]   = r_lb;
        addr[0]   = l_addr;  addr[1]   = r_addr;
        wdata[0]  = l_wdata; wdata[1]  = r_wdata;
        l_rdata   = rdata[0];
        r_rdata   = rdata[1];
    end

    for (genvar s = 0; s < 2; s++) begin : g_side
        dpram_port_ctl u_ctl (
            .ce_n (ce_n_v[s]),
            .ce   (ce_v[s]),
            .we_n (we_n_v[s]),
            .oe   (oe_v[s]),
            .ub   (ub_v[s]),
            .lb   (lb_v[s]),
            .ctl  (ctl[s])
        );
    end

    dpram_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .master_sel (master_sel),
        .ctl_l      (ctl[0]),
        .ctl_r      (ctl[1]),
        .addr_l     (addr[0]),
        .addr_r     (addr[1]),
        .busy_in_l  (l_busy_in),
        .busy_in_r  (r_busy_in),
        .busy_out_l (l_busy_out),
        .busy_out_r (r_busy_out),
        .block_l    (block[0]),
        .block_r    (block[1])
    );

    dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .addr  (addr),
        .wdata (wdata),
        .block (block),
        .rdata (rdata)
    );

    // R1: a write with an inactive enable does not reach the array
    p_enable_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n || !l_ce) |-> !ctl[0].wr);
endmodule

// File: tb/dpram_busy_test.sv
`timescale 1ns/1ps
module dpram_busy_test;
    localparam int AW = 4;
    localparam int DW = 18;
    localparam int LW = DW / 2;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_sel = 1'b1;
    logic l_ce_n, l_ce, l_we_n, l_oe, l_ub, l_lb, l_busy_in;
    logic r_ce_n, r_ce, r_we_n, r_oe, r_ub, r_lb, r_busy_in;
    logic [AW-1:0] l_addr, r_addr;
    logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;
    logic l_busy_out, r_busy_out;

    logic [DW-1:0] model [DEPTH];
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    dpram_busy #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .master_sel(master_sel),
        .l_ce_n(l_ce_n), .l_ce(l_ce), .l_we_n(l_we_n), .l_oe(l_oe),
        .l_ub(l_ub), .l_lb(l_lb), .l_addr(l_addr), .l_wdata(l_wdata),
        .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
        .r_ce_n(r_ce_n), .r_ce(r_ce), .r_we_n(r_we_n), .r_oe(r_oe),
        .r_ub(r_ub), .r_lb(r_lb), .r_addr(r_addr), .r_wdata(r_wdata),
        .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
    );

    function automatic logic [DW-1:0] lanes(logic [DW-1:0] v, logic ub, logic lb);
        logic [DW-1:0] m = '0;
        if (lb) m[LW-1:0]  = v[LW-1:0];
        if (ub) m[DW-1:LW] = v[DW-1:LW];
        return m;
    endfunction

    function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw,
                                            logic ub, logic lb);
        logic [DW-1:0] m = old;
        if (lb) m[LW-1:0]  = nw[LW-1:0];
        if (ub) m[DW-1:LW] = nw[DW-1:LW];
        return m;
    endfunction

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_ce_n = 1; l_ce = 0; l_we_n = 1; l_oe = 0; l_ub = 1; l_lb = 1;
        r_ce_n = 1; r_ce = 0; r_we_n = 1; r_oe = 0; r_ub = 1; r_lb = 1;
        l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
        l_busy_in = 0; r_busy_in = 0;
    endtask

    task automatic set_l(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic ub, logic lb);
        l_ce_n = 0; l_ce = 1; l_we_n = ~wr; l_oe = 1; l_ub = ub; l_lb = lb;
        l_addr = a; l_wdata = d;
    endtask

    task automatic set_r(logic wr, logic [AW-1:0] a, logic [DW-1:0] d, logic ub, logic lb);
        r_ce_n = 0; r_ce = 1; r_we_n = ~wr; r_oe = 1; r_ub = ub; r_lb = lb;
        r_addr = a; r_wdata = d;
    endtask

    // inputs are set at a falling edge; this applies one cycle and checks it
    task automatic cycle(string tag);
        logic en_l, en_r, clash, blk_l, blk_r;
        logic [DW-1:0] exp_l, exp_r;
        #1;
        en_l  = !l_ce_n && l_ce;
        en_r  = !r_ce_n && r_ce;
        clash = en_l && en_r && (l_addr == r_addr);
        check({tag, " busy_l"}, DW'(l_busy_out), '0);
        check({tag, " busy_r"}, DW'(r_busy_out), DW'(master_sel && clash));
        blk_l = master_sel ? 1'b0 : l_busy_in;
        blk_r = master_sel ? clash : r_busy_in;
        exp_l = (en_l && l_oe && l_we_n) ? lanes(model[l_addr], l_ub, l_lb) : '0;
        exp_r = (en_r && r_oe && r_we_n) ? lanes(model[r_addr], r_ub, r_lb) : '0;
        if (en_r && !r_we_n && !blk_r) model[r_addr] = merge(model[r_addr], r_wdata, r_ub, r_lb);
        if (en_l && !l_we_n && !blk_l) model[l_addr] = merge(model[l_addr], l_wdata, l_ub, l_lb);
        @(posedge clk);
        @(negedge clk);
        check({tag, " rdata_l"}, l_rdata, exp_l);
        check({tag, " rdata_r"}, r_rdata, exp_r);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        repeat (3) @(negedge clk);
        check("R2 reset l_rdata", l_rdata, '0);
        check("R2 reset r_rdata", r_rdata, '0);
        rst_n = 1;
        @(negedge clk);

        // fill: both ports write distinct halves of the array together
        for (int i = 0; i < DEPTH / 2; i++) begin
            idle();
            set_l(1, AW'(i), DW'(i * 7 + 3), 1, 1);
            set_r(1, AW'(i + DEPTH / 2), DW'(i * 11 + 5), 1, 1);
            cycle("R3 R9 fill");
        end

        // R1: each inactive enable blocks a write
        idle(); set_l(1, 4'd2, 18'h3ffff, 1, 1); l_ce_n = 1; cycle("R1 ce_n high");
        idle(); set_l(1, 4'd2, 18'h3ffff, 1, 1); l_ce = 0;   cycle("R1 ce low");
        idle(); set_l(0, 4'd2, '0, 1, 1);                    cycle("R1 readback");

        // R3/R4: one lane written at a time, read with one lane selected
        idle(); set_l(1, 4'd5, 18'h2aaaa, 0, 1); cycle("R3 low lane");
        idle(); set_r(1, 4'd5, 18'h15555, 1, 0); cycle("R3 high lane");
        idle(); set_l(0, 4'd5, '0, 1, 0);        cycle("R4 upper only");
        idle(); set_r(0, 4'd5, '0, 0, 1);        cycle("R4 lower only");
        idle(); set_l(0, 4'd5, '0, 1, 1); l_oe = 0; cycle("R2 oe low");

        // R5/R6: tie on the same word, the left write lands
        idle(); set_l(1, 4'd9, 18'h11111, 1, 1); set_r(1, 4'd9, 18'h22222, 1, 1);
        cycle("R5 R6 tie");
        idle(); set_r(0, 4'd9, '0, 1, 1); cycle("R6 readback");

        // R8: write on left, read on right of the same word
        idle(); set_l(1, 4'd12, 18'h0abcd, 1, 1); set_r(0, 4'd12, '0, 1, 1);
        cycle("R8 old data");
        idle(); set_r(0, 4'd12, '0, 1, 1); cycle("R8 new data");

        // R7: slave mode, busy input blocks the right write
        master_sel = 0;
        idle(); set_r(1, 4'd3, 18'h33333, 1, 1); r_busy_in = 1; cycle("R7 blocked");
        idle(); set_l(1, 4'd3, 18'h12345, 1, 1); set_r(0, 4'd3, '0, 1, 1); cycle("R7 slave tie");
        idle(); set_r(0, 4'd3, '0, 1, 1); cycle("R7 readback");
        master_sel = 1;

        for (int n = 0; n < 3000; n++) begin
            if (n % 250 == 0) master_sel = ($urandom % 4) != 0;
            l_ce_n = ($urandom % 8) == 0;  l_ce = ($urandom % 8) != 0;
            r_ce_n = ($urandom % 8) == 0;  r_ce = ($urandom % 8) != 0;
            l_we_n = $urandom % 2;         r_we_n = $urandom % 2;
            l_oe = ($urandom % 6) != 0;    r_oe = ($urandom % 6) != 0;
            l_ub = ($urandom % 4) != 0;    l_lb = ($urandom % 4) != 0;
            r_ub = ($urandom % 4) != 0;    r_lb = ($urandom % 4) != 0;
            l_addr = AW'($urandom);        r_addr = AW'($urandom);
            l_wdata = DW'($urandom);       r_wdata = DW'($urandom);
            l_busy_in = ($urandom % 3) == 0;
            r_busy_in = ($urandom % 3) == 0;
            cycle("R2 R5 R6 R7 R8 random");
        end
        finish_run();
    end
endmodule